// File: doc/BRIEF.md
# Programmable Interval Timer with Retrigger Immunity

This block is a synchronous trigger/reset interval timer. A one-cycle trigger pulse starts an up-counter that advances on every time-base tick, a one-cycle enable supplied from outside. While the timer runs, each counter output shows one bit of the count. Output k is therefore low for 2^k ticks after a trigger. While the timer is idle, every output sits high. A select mask picks a subset of the outputs. Their wired-AND forms a combined output, which is low while any selected output is low.

In one-shot mode, the combined output is fed back as a stop. The run ends on its own once every selected output has gone high, so the combined output stays low for a number of ticks equal to the mask value. In free-running mode there is no feedback. The count wraps and continues until the stop input is pulsed. While running, the timer ignores a further trigger on its own. A trigger that arrives together with a stop restarts the count, because the trigger has priority.

The controller is a two-state machine. IDLE moves to RUN on START, which is an accepted trigger. RUN stays in RUN on RESTART, which is a trigger together with a stop. RUN moves to IDLE on HALT, which is a stop without a trigger. RUN moves to IDLE on EXPIRE, which is a one-shot self-stop on a tick while the combined output is high. Every other case holds the current state.

Top module: `interval_timer`

## Requirements
- R1: After the system reset `rst_n` is released, the timer is idle, `outs` is all ones and `combo` is 1.
- R2: A trigger accepted while idle makes `outs` all zeros in the next cycle, and the timer is running. A trigger is accepted when `astable`=1 or when `sel_mask` is nonzero.
- R3: While running, a trigger without a stop has no effect. The count holds if there is no tick and advances by one if there is a tick.
- R4: A trigger and a stop in the same cycle while running make `outs` all zeros in the next cycle, and the timer keeps running.
- R5: A stop without a trigger makes `outs` all ones in the next cycle. The outputs then stay all ones while idle, whatever ticks arrive.
- R6: While running, `outs` is the binary count. It increments by one in the cycle after each tick and holds when there is no tick. Bit k (weight 2^k) therefore stays low for 2^k ticks after a trigger.
- R7: `combo` is the AND of the `outs` bits whose `sel_mask` bit is 1. It is low while any selected output is low.
- R8: With `astable`=0, a tick that arrives while running with `combo` high returns the timer to idle in the next cycle. `combo` is then low for exactly `sel_mask` ticks.
- R9: With `astable`=0 and `sel_mask`=0, a trigger is ignored and the timer stays idle.
- R10: With `astable`=1, the count wraps from all ones to zero and the timer keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| tb_tick | input | 1 | Time-base tick, one cycle wide |
| trig | input | 1 | Trigger pulse |
| halt | input | 1 | Stop pulse |
| sel_mask | input | WIDTH | Selects which outputs form `combo` |
| astable | input | 1 | 1 = free-running, 0 = one-shot with self-stop |
| outs | output | WIDTH | Counter outputs, all ones while idle |
| combo | output | 1 | Wired-AND of the selected outputs |

## Verification
The bench builds the timer with its default width of 8, so a full 256-tick run fits easily within the cycle budget. At this width the bench can reach the wrap from 255 to 0 in free-running mode. It can also time the top output, which is low for 128 ticks, through a complete one-shot run with only that bit selected. These two cases exercise the widest count value and the longest self-stop interval.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
    import tmr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic             halt,
    input  logic             tick,
    input  logic             astable,
    input  logic [WIDTH-1:0] mask,
    input  logic             combo,
    output logic             run,
    output logic             load,
    output logic             inc
);
    tmr_state_e state, nxt;
    logic start_ok, expire;

    // Trigger is only meaningful when the run could end by feedback or by stop.
    assign start_ok = astable || (mask != '0);
    assign expire   = (state == ST_RUN) && !astable && tick && combo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (trig && start_ok) nxt = ST_RUN;       // START
            ST_RUN: begin
                if (trig && halt && start_ok) nxt = ST_RUN;    // RESTART
                else if (halt)                nxt = ST_IDLE;   // HALT
                else if (expire)              nxt = ST_IDLE;   // EXPIRE
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        run  = (state == ST_RUN);
        load = trig && start_ok && ((state == ST_IDLE) || halt);
        inc  = (state == ST_RUN) && tick && !halt && !expire && !load;
    end

    // R5: a stop without a trigger leaves the machine idle.
    p_halt_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !trig) |=> (state == ST_IDLE));

    // R9: one-shot mode with an empty mask never leaves idle.
    p_mask0_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && !astable && (mask == '0)) |=> (state == ST_IDLE));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             inc,
    output logic [WIDTH-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= '0;
        else if (inc)  cnt <= cnt + 1'b1;
    end

    // R2: a load leaves the count at zero.
    p_load_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == '0));
endmodule

// File: rtl/tmr_outs.sv
module tmr_outs #(
    parameter int WIDTH = 8
) (
    input  logic             run,
    input  logic [WIDTH-1:0] cnt,
    input  logic [WIDTH-1:0] mask,
    output logic [WIDTH-1:0] outs,
    output logic             combo
);
    logic [WIDTH-1:0] term;

    for (genvar k = 0; k < WIDTH; k++) begin : g_bit
        assign outs[k] = run ? cnt[k] : 1'b1;
        assign term[k] = outs[k] | ~mask[k];   // unselected lines pull nothing low
    end

    assign combo = &term;
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tb_tick,
    input  logic             trig,
    input  logic             halt,
    input  logic [WIDTH-1:0] sel_mask,
    input  logic             astable,
    output logic [WIDTH-1:0] outs,
    output logic             combo
);
    logic             run, load, inc;
    logic [WIDTH-1:0] cnt;

    tmr_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .trig(trig), .halt(halt), .tick(tb_tick),
        .astable(astable), .mask(sel_mask), .combo(combo),
        .run(run), .load(load), .inc(inc)
    );

    tmr_count #(.WIDTH(WIDTH)) u_count (
        .clk(clk), .rst_n(rst_n), .load(load), .inc(inc), .cnt(cnt)
    );

    tmr_outs #(.WIDTH(WIDTH)) u_outs (
        .run(run), .cnt(cnt), .mask(sel_mask), .outs(outs), .combo(combo)
    );

    // R3 / R6: running with no tick and no stop keeps the outputs steady.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tb_tick && !halt) |=> $stable(outs));

    // R6 / R10: a counting tick advances the outputs by one, modulo 2^WIDTH.
    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tb_tick && !trig && !halt && (astable || !combo))
        |=> (outs == WIDTH'($past(outs) + 1'b1)));

    // R8: one-shot self-stop on a tick with the combined line high.
    p_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !astable && tb_tick && combo && !halt) |=> (!run && (outs == '1)));

    // R4: trigger beats a simultaneous stop while running.
    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && trig && halt) |=> (run && (outs == '0)));
endmodule

// File: tb/sim_interval_timer.sv
module sim_interval_timer;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tb_tick = 1'b0, trig = 1'b0, halt = 1'b0, astable = 1'b0;
    logic [W-1:0] sel_mask = '0;
    logic [W-1:0] outs;
    logic         combo;
    int           n_chk = 0, n_bad = 0;
    bit           done = 1'b0;

    interval_timer #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .trig(trig), .halt(halt),
        .sel_mask(sel_mask), .astable(astable), .outs(outs), .combo(combo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock with the given pulses; sampled 1 time unit after the edge.
    task automatic cyc(input logic tk, input logic tr, input logic hl);
        @(negedge clk);
        tb_tick = tk; trig = tr; halt = hl;
        @(posedge clk);
        #1;
        tb_tick = 1'b0; trig = 1'b0; halt = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 outs", outs, 255);
        chk("R1 combo", combo, 1);
    endtask

    task automatic t_oneshot;
        astable = 1'b0; sel_mask = 8'h05;
        cyc(0, 1, 0);
        chk("R2 outs", outs, 0);
        chk("R7 combo low", combo, 0);
        for (int i = 1; i <= 4; i++) begin
            cyc(1, 0, 0);
            chk("R6 count", outs, i);
            chk("R7 combo", combo, 0);
            if (i == 2) begin
                cyc(0, 1, 0);
                chk("R3 trig ignored", outs, 2);
                cyc(0, 0, 0);
                chk("R6 hold", outs, 2);
            end
        end
        cyc(1, 0, 0);
        chk("R7 combo high", combo, 1);
        chk("R6 count5", outs, 5);
        cyc(1, 0, 0);
        chk("R8 idle", outs, 255);
    endtask

    task automatic t_halt;
        astable = 1'b1; sel_mask = 8'h01;
        cyc(0, 1, 0);
        for (int i = 0; i < 3; i++) cyc(1, 0, 0);
        chk("R6 at3", outs, 3);
        cyc(0, 0, 1);
        chk("R5 halted", outs, 255);
        cyc(1, 0, 0);
        cyc(1, 0, 0);
        chk("R5 ticks idle", outs, 255);
    endtask

    task automatic t_both;
        astable = 1'b1; sel_mask = 8'h02;
        cyc(0, 1, 0);
        for (int i = 0; i < 5; i++) cyc(1, 0, 0);
        cyc(1, 1, 1);
        chk("R4 restart", outs, 0);
        cyc(1, 0, 0);
        chk("R4 still running", outs, 1);
        cyc(0, 0, 1);
    endtask

    task automatic t_mask0;
        astable = 1'b0; sel_mask = 8'h00;
        cyc(0, 1, 0);
        chk("R9 idle", outs, 255);
        cyc(1, 0, 0);
        chk("R9 idle tick", outs, 255);
    endtask

    task automatic t_wrap;
        astable = 1'b1; sel_mask = 8'hFF;
        cyc(0, 1, 0);
        for (int i = 0; i < 255; i++) cyc(1, 0, 0);
        chk("R10 at max", outs, 255);
        chk("R7 all set", combo, 1);
        cyc(1, 0, 0);
        chk("R10 wrapped", outs, 0);
        cyc(1, 0, 0);
        chk("R10 running", outs, 1);
        cyc(0, 0, 1);
    endtask

    task automatic t_weight;
        astable = 1'b0; sel_mask = 8'h80;
        cyc(0, 1, 0);
        for (int i = 0; i < 127; i++) cyc(1, 0, 0);
        chk("R6 bit7 low", outs[7], 0);
        chk("R8 combo low", combo, 0);
        cyc(1, 0, 0);
        chk("R6 bit7 high", outs[7], 1);
        chk("R8 combo high", combo, 1);
        cyc(1, 0, 0);
        chk("R8 self stop", outs, 255);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_oneshot();
        t_halt();
        t_both();
        t_mask0();
        t_wrap();
        t_weight();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            #(CLK_PERIOD * 200000);
        join_any
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule